// File: doc/BRIEF.md
# E1 CRC4 Interworking Search Controller

This block decides, after basic E1 frame alignment has been acquired, whether the receive side runs with CRC4 multiframing or falls back to plain doubleframe operation. A frame-level aligner feeds it a basic-alignment level, the bit position of that alignment, a pulse when a multiframe pattern is found together with the position that multiframe implies, and a 1 ms strobe. Once basic alignment appears, the block latches that position as the primary one and opens a search window of `WIN_MS` strobes (400 by default).

A multiframe found inside the window moves the link into CRC4 mode. The primary position is then replaced by the multiframe's position, and an adjust pulse is raised when the two differed. CRC checking is enabled only when the monitoring enable is also set. If the window closes first, the link drops to non-CRC4 mode. In that mode a status flag stays set, a one-cycle interrupt fires, CRC checks are blocked and received E-bits are forced low. With extended interworking selected, the timeout does not cause a fallback. The block keeps searching and holds a request for the transmitter to send the A-bit as 1 until a multiframe turns up. Transmit framing is never touched. Losing basic alignment at any point sends the block back to idle.

Top module: `crc4_iw_ctrl`

## Requirements
- R1: After synchronous reset every output is 0 and the controller is idle.
- R2: The window opens on the clock edge where `bfa_ok` is first seen high in idle. That edge latches `fas_pos` into `prim_pos`. Strobes are counted only after that edge, and the window closes on the `WIN_MS`-th counted strobe.
- R3: If the window closes with `ext_iw` low, the controller goes to non-CRC4 mode. On that edge `nomf_sts` rises and stays high until basic alignment is lost, and `t400_irq` is high for exactly one cycle.
- R4: In non-CRC4 mode `ebit_force_low` is 1 and both `crc_chk_en` and `crc4_mode` are 0. A later `mfa_hit` is ignored.
- R5: While the search runs, changes on `fas_pos` do not alter `prim_pos`.
- R6: An `mfa_hit` during the search (normal or extended) sets `crc4_mode` and loads `mfa_pos` into `prim_pos`. `adj_req` pulses for one cycle only when `mfa_pos` differed from the old `prim_pos`.
- R7: `crc_chk_en` is 1 only in CRC4 mode, and only while `crc_mon_en` was 1 at the previous clock edge.
- R8: If the window closes with `ext_iw` high, there is no fallback, no status and no interrupt. `ext_abit_req` stays 1 until an `mfa_hit` moves the link to CRC4 mode.
- R9: When `bfa_ok` is low at a clock edge, every output, `prim_pos` included, is 0 after that edge. The window count restarts from zero when alignment is regained.
- R10: `ext_iw` is used only at the edge where the window closes. Its value earlier in the window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | 1 ms strobe, one cycle wide |
| bfa_ok | input | 1 | Basic frame alignment held |
| fas_pos | input | POS_W | Bit position of the current basic alignment |
| mfa_hit | input | 1 | Multiframe alignment found, one-cycle pulse |
| mfa_pos | input | POS_W | Basic alignment position implied by that multiframe |
| ext_iw | input | 1 | Extended interworking: no timeout fallback |
| crc_mon_en | input | 1 | Allow CRC4 checking once in CRC4 mode |
| crc4_mode | output | 1 | Link in CRC4 multiframe mode |
| crc_chk_en | output | 1 | CRC checking enabled |
| ebit_force_low | output | 1 | Force received E-bits to 0 |
| nomf_sts | output | 1 | No multiframe found (sticky) |
| t400_irq | output | 1 | Window expiry interrupt, one cycle |
| adj_req | output | 1 | Primary position adjust, one cycle |
| prim_pos | output | POS_W | Primary basic alignment position |
| ext_abit_req | output | 1 | Request A-bit = 1 on transmit |

## Verification
Every output is a flop loaded from the next state, so a wrong internal state appears at the ports one cycle after the edge that caused it. Several faults need a whole window before they show. A timer that miscounts moves the rise of `nomf_sts` or `ext_abit_req` away from the `WIN_MS`-th strobe. A primary position that drifts during the search shows up only at the next `prim_pos` readout or as a missing `adj_req`. A mode flop left stale after alignment loss is caught on the cycle that follows the loss.

// File: rtl/crc4_iw_pkg.sv
package crc4_iw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SRCH = 3'd1,
    ST_CRC4 = 3'd2,
    ST_NOMF = 3'd3,
    ST_XSRCH = 3'd4
  } iw_state_e;
endpackage

// File: rtl/crc4_iw_win_timer.sv
module crc4_iw_win_timer #(
  parameter int WIN_MS = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick_ms,
  output logic win_done
);
  localparam int CNT_W = (WIN_MS > 2) ? $clog2(WIN_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign win_done = en && tick_ms && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (tick_ms) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R2: count stays inside the window and clears whenever searching stops
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_q == '0);
endmodule

// File: rtl/crc4_iw_fsm.sv
module crc4_iw_fsm
  import crc4_iw_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bfa_ok,
  input  logic [POS_W-1:0] fas_pos,
  input  logic             mfa_hit,
  input  logic [POS_W-1:0] mfa_pos,
  input  logic             win_done,
  input  logic             ext_iw,
  input  logic             crc_mon_en,
  output logic             srch_act,
  output logic             crc4_mode,
  output logic             crc_chk_en,
  output logic             ebit_force_low,
  output logic             nomf_sts,
  output logic             t400_irq,
  output logic             adj_req,
  output logic [POS_W-1:0] prim_pos,
  output logic             ext_abit_req
);
  iw_state_e st_q, st_d;
  logic      take_mfa;

  assign srch_act = (st_q == ST_SRCH);
  assign take_mfa = bfa_ok && mfa_hit && (st_q == ST_SRCH || st_q == ST_XSRCH);

  always_comb begin
    st_d = st_q;
    if (!bfa_ok) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_SRCH;
        ST_SRCH: begin
          if (mfa_hit) st_d = ST_CRC4;
          else if (win_done) st_d = ext_iw ? ST_XSRCH : ST_NOMF;
        end
        ST_XSRCH: if (mfa_hit) st_d = ST_CRC4;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      crc4_mode      <= 1'b0;
      crc_chk_en     <= 1'b0;
      ebit_force_low <= 1'b0;
      nomf_sts       <= 1'b0;
      t400_irq       <= 1'b0;
      adj_req        <= 1'b0;
      prim_pos       <= '0;
      ext_abit_req   <= 1'b0;
    end else begin
      st_q           <= st_d;
      crc4_mode      <= (st_d == ST_CRC4);
      crc_chk_en     <= (st_d == ST_CRC4) && crc_mon_en;
      ebit_force_low <= (st_d == ST_NOMF);
      nomf_sts       <= (st_d == ST_NOMF);
      t400_irq       <= (st_q == ST_SRCH) && (st_d == ST_NOMF);
      ext_abit_req   <= (st_d == ST_XSRCH);
      adj_req        <= take_mfa && (mfa_pos != prim_pos);
      if (st_d == ST_IDLE) prim_pos <= '0;
      else if (st_q == ST_IDLE) prim_pos <= fas_pos;
      else if (take_mfa) prim_pos <= mfa_pos;
    end
  end

  // R3: the expiry interrupt is a single-cycle pulse, status sticks while aligned
  p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
    t400_irq |=> !t400_irq);
  p_nomf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (nomf_sts && bfa_ok) |=> nomf_sts);
  // R4: forced E-bits never coexist with CRC checking
  p_nomf_nochk_r4: assert property (@(posedge clk) disable iff (rst)
    ebit_force_low |-> (!crc_chk_en && !crc4_mode));
  // R5: primary position locked during the plain search
  p_prim_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SRCH && bfa_ok && !mfa_hit) |=> $stable(prim_pos));
  // R6: an adjust only accompanies entry to CRC4 mode
  p_adj_crc_r6: assert property (@(posedge clk) disable iff (rst)
    adj_req |-> crc4_mode);
  // R8: the A-bit request excludes both resolved modes
  p_abit_excl_r8: assert property (@(posedge clk) disable iff (rst)
    ext_abit_req |-> (!crc4_mode && !nomf_sts));
  // R9: loss of basic alignment clears everything
  p_loss_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !bfa_ok |=> (!crc4_mode && !ext_abit_req && !adj_req && !nomf_sts && prim_pos == '0));
endmodule

// File: rtl/crc4_iw_ctrl.sv
module crc4_iw_ctrl #(
  parameter int WIN_MS = 400,
  parameter int POS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             bfa_ok,
  input  logic [POS_W-1:0] fas_pos,
  input  logic             mfa_hit,
  input  logic [POS_W-1:0] mfa_pos,
  input  logic             ext_iw,
  input  logic             crc_mon_en,
  output logic             crc4_mode,
  output logic             crc_chk_en,
  output logic             ebit_force_low,
  output logic             nomf_sts,
  output logic             t400_irq,
  output logic             adj_req,
  output logic [POS_W-1:0] prim_pos,
  output logic             ext_abit_req
);
  logic srch_act;
  logic win_done;

  crc4_iw_win_timer #(.WIN_MS(WIN_MS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .en       (srch_act),
    .tick_ms  (tick_ms),
    .win_done (win_done)
  );

  crc4_iw_fsm #(.POS_W(POS_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .bfa_ok         (bfa_ok),
    .fas_pos        (fas_pos),
    .mfa_hit        (mfa_hit),
    .mfa_pos        (mfa_pos),
    .win_done       (win_done),
    .ext_iw         (ext_iw),
    .crc_mon_en     (crc_mon_en),
    .srch_act       (srch_act),
    .crc4_mode      (crc4_mode),
    .crc_chk_en     (crc_chk_en),
    .ebit_force_low (ebit_force_low),
    .nomf_sts       (nomf_sts),
    .t400_irq       (t400_irq),
    .adj_req        (adj_req),
    .prim_pos       (prim_pos),
    .ext_abit_req   (ext_abit_req)
  );
endmodule

// File: tb/crc4_iw_ctrl_tb_top.sv
module crc4_iw_ctrl_tb_top;
  localparam int WIN   = 400;
  localparam int POS_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 0, bfa_ok = 0, mfa_hit = 0, ext_iw = 0, crc_mon_en = 0;
  logic [POS_W-1:0] fas_pos = '0, mfa_pos = '0;
  logic crc4_mode, crc_chk_en, ebit_force_low, nomf_sts, t400_irq, adj_req, ext_abit_req;
  logic [POS_W-1:0] prim_pos;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  crc4_iw_ctrl #(.WIN_MS(WIN), .POS_W(POS_W)) dut_i (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .bfa_ok(bfa_ok), .fas_pos(fas_pos),
    .mfa_hit(mfa_hit), .mfa_pos(mfa_pos), .ext_iw(ext_iw), .crc_mon_en(crc_mon_en),
    .crc4_mode(crc4_mode), .crc_chk_en(crc_chk_en), .ebit_force_low(ebit_force_low),
    .nomf_sts(nomf_sts), .t400_irq(t400_irq), .adj_req(adj_req), .prim_pos(prim_pos),
    .ext_abit_req(ext_abit_req)
  );

  // reference model of the requirements: 0 idle, 1 search, 2 crc4, 3 no-mf, 4 ext search
  int m_st = 0, m_cnt = 0;
  logic m_crc = 0, m_chk = 0, m_ebit = 0, m_nomf = 0, m_irq = 0, m_adj = 0, m_abit = 0;
  logic [POS_W-1:0] m_prim = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_prim = '0; m_adj = 0; m_irq = 0;
    end else begin
      m_irq = 0; m_adj = 0;
      if (!bfa_ok) begin
        m_st = 0; m_cnt = 0; m_prim = '0;
      end else begin
        case (m_st)
          0: begin m_st = 1; m_cnt = 0; m_prim = fas_pos; end
          1: if (mfa_hit) begin
               m_adj = (mfa_pos != m_prim); m_prim = mfa_pos; m_st = 2;
             end else if (tick_ms) begin
               m_cnt++;
               if (m_cnt == WIN) begin
                 if (ext_iw) m_st = 4;
                 else begin m_st = 3; m_irq = 1; end
               end
             end
          4: if (mfa_hit) begin
               m_adj = (mfa_pos != m_prim); m_prim = mfa_pos; m_st = 2;
             end
          default: ;
        endcase
      end
    end
    m_crc  = (m_st == 2);
    m_chk  = (m_st == 2) && crc_mon_en && !rst;
    m_ebit = (m_st == 3);
    m_nomf = (m_st == 3);
    m_abit = (m_st == 4);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic cmp_all();
    chk("R6", "crc4_mode", crc4_mode, m_crc);
    chk("R7", "crc_chk_en", crc_chk_en, m_chk);
    chk("R4", "ebit_force_low", ebit_force_low, m_ebit);
    chk("R3", "nomf_sts", nomf_sts, m_nomf);
    chk("R3", "t400_irq", t400_irq, m_irq);
    chk("R6", "adj_req", adj_req, m_adj);
    chk("R5", "prim_pos", prim_pos, m_prim);
    chk("R8", "ext_abit_req", ext_abit_req, m_abit);
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    cmp_all();
    tick_ms = 0; mfa_hit = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int seed;
    int down;
    seed = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "outputs at reset", {crc4_mode, crc_chk_en, ebit_force_low, nomf_sts,
        t400_irq, adj_req, ext_abit_req}, 0);
    chk("R1", "prim_pos at reset", prim_pos, 0);
    rst = 0;

    // R2 / R5 / R10: exact window, fas_pos wiggle and ext_iw raised only mid-window
    fas_pos = 8'd17; bfa_ok = 1; crc_mon_en = 1;
    step();
    chk("R2", "prim_pos latched", prim_pos, 17);
    for (int i = 0; i < WIN - 1; i++) begin
      tick_ms = 1; fas_pos = 8'(i); ext_iw = (i > 100 && i < 200);
      step();
    end
    chk("R2", "nomf before last tick", nomf_sts, 0);
    chk("R5", "prim_pos held", prim_pos, 17);
    tick_ms = 1; ext_iw = 0;
    step();
    chk("R2", "nomf on last tick", nomf_sts, 1);
    chk("R10", "fallback despite early ext_iw", ext_abit_req, 0);
    chk("R3", "irq pulse", t400_irq, 1);
    step();
    chk("R3", "irq single", t400_irq, 0);
    mfa_hit = 1; mfa_pos = 8'd3;
    step();
    chk("R4", "mfa ignored in no-mf", crc4_mode, 0);

    // R9: loss clears, then extended mode path
    bfa_ok = 0;
    step();
    chk("R9", "nomf cleared on loss", nomf_sts, 0);
    chk("R9", "prim cleared on loss", prim_pos, 0);
    bfa_ok = 1; fas_pos = 8'd40; ext_iw = 1;
    step();
    for (int i = 0; i < WIN; i++) begin tick_ms = 1; step(); end
    chk("R8", "A-bit request after window", ext_abit_req, 1);
    chk("R8", "no status in ext mode", nomf_sts, 0);
    mfa_hit = 1; mfa_pos = 8'd41;
    step();
    chk("R8", "A-bit released", ext_abit_req, 0);
    chk("R6", "adjust pulse", adj_req, 1);
    chk("R6", "new primary", prim_pos, 41);
    bfa_ok = 0; step();
    chk("R9", "adj and crc4 cleared", {crc4_mode, adj_req}, 0);
    bfa_ok = 1; fas_pos = 8'd9; step();
    mfa_hit = 1; mfa_pos = 8'd9; step();
    chk("R6", "no adjust on same position", adj_req, 0);
    chk("R7", "check enabled", crc_chk_en, 1);
    crc_mon_en = 0; step();
    chk("R7", "check follows enable", crc_chk_en, 0);

    // random phase
    down = 0;
    for (int c = 0; c < 80000; c++) begin
      tick_ms = (c % 3 == 0);
      if (down > 0) begin bfa_ok = 0; down--; end
      else begin
        bfa_ok = 1;
        if ($urandom_range(2999) == 0) down = $urandom_range(4) + 1;
      end
      mfa_hit = ($urandom_range(1499) == 0);
      mfa_pos = $urandom_range(3) == 0 ? prim_pos : 8'($urandom);
      if (c % 50 == 0) fas_pos = 8'($urandom);
      if ($urandom_range(3999) == 0) ext_iw = ~ext_iw;
      if ($urandom_range(499) == 0) crc_mon_en = ~crc_mon_en;
      step();
    end
    finish_run();
  end
endmodule